// File: doc/BRIEF.md
# Receive Loss-of-Signal Detector

This block sits behind a clock and data recovery stage. On each cycle where the recovered-bit strobe is high, it takes one received bit and decides whether the line carries a signal. A bit counts as a zero when it is received as zero. It also counts as a zero when a separate low-amplitude flag says that the analog level was below threshold for that bit, whatever the bit value.

Loss of signal is declared after a long unbroken run of such zeros. It is withdrawn only when the recent bit history shows enough pulse density. That means a minimum number of ones inside a sliding window, with no zero run inside the window longer than a set bound.

Every change of the indication can raise a single-cycle interrupt pulse. The received bits are passed on, one cycle later, whatever the indication shows. A host status output carries the same level as the indication pin.

Top module: `rx_los_detector`

## Requirements
- R1: Reset is synchronous and active high. During and after reset, `los` and `los_status` are 1 and `los_irq` is 0, and reset itself never produces an interrupt pulse.
- R2: A sampled bit is an effective zero when `rx_bit` is 0 or `amp_low` is 1. An effective zero with `amp_low` = 1 and `rx_bit` = 1 counts exactly like a received zero.
- R3: When `bit_strobe` is 0, `rx_bit` and `amp_low` have no effect. `los` keeps its value and the zero run and window history are unchanged.
- R4: When `los` is 0, it becomes 1 in the cycle after the strobe that carries the ZERO_LIMIT-th consecutive effective zero (175 by default). Any effective one restarts the run, so ZERO_LIMIT-1 zeros, a one, and ZERO_LIMIT-1 more zeros leave `los` at 0.
- R5: When `los` is 1, it becomes 0 in the cycle after a strobe for which the last WINDOW effective bits, the current one included, hold at least MIN_ONES ones and contain no run of zeros longer than MAX_ZERO_RUN (32, 3 and 15 by default). History before reset counts as zeros.
- R6: With `irq_en` = 1, `los_irq` is high for exactly the one cycle in which `los` first shows a new value, for both the rising and the falling change, and is low in every other cycle.
- R7: With `irq_en` = 0 on the strobe that changes `los`, no interrupt pulse is produced.
- R8: `los_status` equals `los` in every cycle.
- R9: `rx_data_vld` is `bit_strobe` delayed by one cycle. When it is 1, `rx_data_out` is the raw `rx_bit` of that strobe, whatever the state of `los` and `amp_low`.
- R10: While `los` is 1, further zeros beyond ZERO_LIMIT keep it at 1 and cause no further interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_strobe | input | 1 | One recovered bit is present this cycle |
| rx_bit | input | 1 | Received bit value |
| amp_low | input | 1 | Signal level below threshold; forces the bit to zero |
| irq_en | input | 1 | Enables the change interrupt |
| rx_data_out | output | 1 | Received bit, passed through |
| rx_data_vld | output | 1 | Qualifier for `rx_data_out` |
| los | output | 1 | Loss-of-signal indication |
| los_irq | output | 1 | One-cycle pulse on each change of `los` |
| los_status | output | 1 | Host-readable copy of `los` |

## Verification
The bench builds the detector with a zero limit of 10, a window of 8 bits, a minimum of 2 ones and a longest allowed zero run of 3. With these values every one of the 256 possible window contents can be placed after a forced loss state. This covers every combination of ones count and run length, on both sides of each exit bound. The short limit also makes it cheap to drive the exact boundary of the entry count, both directly and with a one inserted just before it.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic {
        LOS_CLEAR  = 1'b0,
        LOS_ACTIVE = 1'b1
    } los_state_e;

    typedef struct packed {
        logic vld;   // a recovered bit is present
        logic raw;   // bit as received
        logic zero;  // effective zero after amplitude qualification
    } rx_sample_t;

    function automatic logic eff_zero(input logic bit_in, input logic amp_is_low);
        return (!bit_in) || amp_is_low;
    endfunction

endpackage

// File: rtl/los_front.sv
module los_front
    import los_pkg::*;
(
    input  logic       clk,
    input  logic       bit_strobe,
    input  logic       rx_bit,
    input  logic       amp_low,
    output rx_sample_t smp,
    output logic       data_out,
    output logic       data_vld
);
    always_comb begin
        smp.vld  = bit_strobe;
        smp.raw  = rx_bit;
        smp.zero = eff_zero(rx_bit, amp_low);
    end

    // data path is not reset: it only mirrors the line
    always_ff @(posedge clk) begin
        data_vld <= bit_strobe;
        if (bit_strobe)
            data_out <= rx_bit;
    end
endmodule

// File: rtl/los_zero_run.sv
module los_zero_run
    import los_pkg::*;
#(
    parameter int LIMIT = 175
) (
    input  logic       clk,
    input  logic       rst,
    input  rx_sample_t smp,
    output logic       limit_hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] run_q, run_n;

    always_comb begin
        if (!smp.vld)
            run_n = run_q;
        else if (!smp.zero)
            run_n = '0;
        else if (run_q == LIM_V)
            run_n = run_q;
        else
            run_n = run_q + 1'b1;
    end

    assign limit_hit = smp.vld && (run_n == LIM_V);

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else
            run_q <= run_n;
    end
endmodule

// File: rtl/los_density_win.sv
module los_density_win
    import los_pkg::*;
#(
    parameter int WINDOW       = 32,
    parameter int MIN_ONES     = 3,
    parameter int MAX_ZERO_RUN = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  rx_sample_t smp,
    output logic       exit_ok
);
    localparam int CW      = $clog2(WINDOW + 1);
    localparam int SPAN    = MAX_ZERO_RUN + 1;
    localparam int NSLICE  = WINDOW - SPAN + 1;
    localparam logic [CW-1:0] MIN_V = CW'(MIN_ONES);

    logic [WINDOW-1:0] hist_q, hist_n;
    logic [CW-1:0]     ones;
    logic [NSLICE-1:0] slice_has_one;

    assign hist_n = {hist_q[WINDOW-2:0], ~smp.zero};

    always_comb begin
        ones = '0;
        for (int i = 0; i < WINDOW; i++)
            ones = ones + CW'(hist_n[i]);
    end

    // a zero run longer than MAX_ZERO_RUN exists iff some SPAN-wide slice is all zero
    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        assign slice_has_one[g] = |hist_n[g +: SPAN];
    end

    assign exit_ok = smp.vld && (ones >= MIN_V) && (&slice_has_one);

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (smp.vld)
            hist_q <= hist_n;
    end
endmodule

// File: rtl/los_fsm.sv
module los_fsm
    import los_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic limit_hit,
    input  logic exit_ok,
    input  logic irq_en,
    output logic los,
    output logic irq
);
    los_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LOS_CLEAR:  if (limit_hit) state_n = LOS_ACTIVE;
            LOS_ACTIVE: if (exit_ok)   state_n = LOS_CLEAR;
            default:                   state_n = LOS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LOS_ACTIVE;
            irq     <= 1'b0;
        end else begin
            state_q <= state_n;
            irq     <= irq_en && (state_n != state_q);
        end
    end

    assign los = (state_q == LOS_ACTIVE);
endmodule

// File: rtl/rx_los_detector.sv
module rx_los_detector
    import los_pkg::*;
#(
    parameter int ZERO_LIMIT   = 175,
    parameter int WINDOW       = 32,
    parameter int MIN_ONES     = 3,
    parameter int MAX_ZERO_RUN = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_strobe,
    input  logic rx_bit,
    input  logic amp_low,
    input  logic irq_en,
    output logic rx_data_out,
    output logic rx_data_vld,
    output logic los,
    output logic los_irq,
    output logic los_status
);
    rx_sample_t smp;
    logic       limit_hit;
    logic       exit_ok;
    logic       los_i;

    los_front u_front (
        .clk        (clk),
        .bit_strobe (bit_strobe),
        .rx_bit     (rx_bit),
        .amp_low    (amp_low),
        .smp        (smp),
        .data_out   (rx_data_out),
        .data_vld   (rx_data_vld)
    );

    los_zero_run #(.LIMIT(ZERO_LIMIT)) u_run (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .limit_hit (limit_hit)
    );

    los_density_win #(
        .WINDOW       (WINDOW),
        .MIN_ONES     (MIN_ONES),
        .MAX_ZERO_RUN (MAX_ZERO_RUN)
    ) u_win (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .exit_ok (exit_ok)
    );

    los_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .limit_hit (limit_hit),
        .exit_ok   (exit_ok),
        .irq_en    (irq_en),
        .los       (los_i),
        .irq       (los_irq)
    );

    assign los        = los_i;
    assign los_status = los_i;
endmodule

// File: rtl/los_checker.sv
module los_checker (
    input logic clk,
    input logic rst,
    input logic bit_strobe,
    input logic rx_bit,
    input logic amp_low,
    input logic irq_en,
    input logic rx_data_out,
    input logic rx_data_vld,
    input logic los,
    input logic los_irq
);
    assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_strobe) |-> $stable(los));

    assert_rise_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(los) |-> ($past(bit_strobe) && (!$past(rx_bit) || $past(amp_low))));

    assert_irq_only_on_change_R6: assert property (@(posedge clk) disable iff (rst)
        los_irq |-> (los != $past(los)));

    assert_change_gives_irq_R6: assert property (@(posedge clk) disable iff (rst)
        ((los != $past(los)) && $past(irq_en)) |-> los_irq);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(irq_en) |-> !los_irq);

    assert_vld_follows_R9: assert property (@(posedge clk) disable iff (rst)
        rx_data_vld == $past(bit_strobe));

    assert_data_follows_R9: assert property (@(posedge clk) disable iff (rst)
        $past(bit_strobe) |-> (rx_data_out == $past(rx_bit)));
endmodule

bind rx_los_detector los_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_strobe  (bit_strobe),
    .rx_bit      (rx_bit),
    .amp_low     (amp_low),
    .irq_en      (irq_en),
    .rx_data_out (rx_data_out),
    .rx_data_vld (rx_data_vld),
    .los         (los),
    .los_irq     (los_irq)
);

// File: tb/sim_rx_los_detector.sv
module sim_rx_los_detector;
    localparam int LIM  = 10;
    localparam int WIN  = 8;
    localparam int MINO = 2;
    localparam int MAXZ = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, bit_strobe, rx_bit, amp_low, irq_en;
    logic rx_data_out, rx_data_vld, los, los_irq, los_status;

    rx_los_detector #(
        .ZERO_LIMIT(LIM), .WINDOW(WIN), .MIN_ONES(MINO), .MAX_ZERO_RUN(MAXZ)
    ) u0 (
        .clk(clk), .rst(rst), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
        .amp_low(amp_low), .irq_en(irq_en), .rx_data_out(rx_data_out),
        .rx_data_vld(rx_data_vld), .los(los), .los_irq(los_irq),
        .los_status(los_status)
    );

    int checks = 0;
    int errors = 0;

    // bench-side expectation
    logic [WIN-1:0] hist_m;
    int             zrun_m;
    logic           los_m, irq_m, data_m, vld_m;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic logic dense_enough(input logic [WIN-1:0] h);
        int ones = 0;
        int run  = 0;
        int maxr = 0;
        for (int i = 0; i < WIN; i++) begin
            if (h[i]) begin
                ones++;
                run = 0;
            end else begin
                run++;
                if (run > maxr) maxr = run;
            end
        end
        return (ones >= MINO) && (maxr <= MAXZ);
    endfunction

    task automatic model_reset();
        hist_m = '0; zrun_m = 0; los_m = 1'b1; irq_m = 1'b0; vld_m = 1'b0;
    endtask

    task automatic step(input logic s, input logic b, input logic a, input logic en,
                        input string req);
        logic prev;
        @(negedge clk);
        bit_strobe = s; rx_bit = b; amp_low = a; irq_en = en;
        @(posedge clk);
        prev = los_m;
        if (s) begin
            logic e;
            e = b && !a;
            hist_m = {hist_m[WIN-2:0], e};
            if (e) zrun_m = 0;
            else if (zrun_m < LIM) zrun_m++;
            if (!los_m && zrun_m == LIM) los_m = 1'b1;
            else if (los_m && dense_enough(hist_m)) los_m = 1'b0;
            data_m = b;
        end
        irq_m = en && (prev != los_m);
        vld_m = s;
        #1;
        chk(req, "los", los, los_m);
        chk(en ? "R6" : "R7", "los_irq", los_irq, irq_m);
        chk("R8", "los_status", los_status, los_m);
        chk("R9", "rx_data_vld", rx_data_vld, vld_m);
        if (vld_m) chk("R9", "rx_data_out", rx_data_out, data_m);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_strobe = 1'b0; rx_bit = 1'b0; amp_low = 1'b0; irq_en = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R1", "los in reset", los, 1'b1);
        chk("R1", "irq in reset", los_irq, 1'b0);
        chk("R1", "status in reset", los_status, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(posedge clk);
        #1;
        chk("R1", "los after reset", los, 1'b1);
        chk("R1", "irq after reset", los_irq, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bit_strobe = 1'b0; rx_bit = 1'b0; amp_low = 1'b0; irq_en = 1'b1;
        model_reset();
        do_reset();

        // R3: ones without a strobe must not clear the indication
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R3");

        // R4/R5: every window content after a forced loss state
        for (int p = 0; p < 256; p++) begin
            for (int k = 0; k < LIM; k++) step(1'b1, 1'b0, 1'b0, 1'b1, "R4");
            for (int i = 0; i < WIN; i++) begin
                step(1'b1, p[i], 1'b0, 1'b1, "R5");
                if (p[0]) step(1'b0, 1'b1, 1'b0, 1'b1, "R3");
            end
        end

        // clear, then R2: ones under low amplitude count as zeros
        for (int i = 0; i < WIN; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R5");
        chk("R5", "cleared before R2 test", los, 1'b0);
        for (int k = 0; k < LIM; k++) step(1'b1, 1'b1, 1'b1, 1'b1, "R2");
        chk("R2", "low amplitude sets loss", los, 1'b1);

        // clear, then R4: a one restarts the zero run
        for (int i = 0; i < WIN; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R5");
        for (int k = 0; k < LIM - 1; k++) step(1'b1, 1'b0, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R4");
        for (int k = 0; k < LIM - 1; k++) step(1'b1, 1'b0, 1'b0, 1'b1, "R4");
        chk("R4", "restarted run stays clear", los, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b1, "R4");
        chk("R4", "limit reached after restart", los, 1'b1);

        // R10: continued zeros keep loss and raise no new pulse
        for (int k = 0; k < LIM + 20; k++) step(1'b1, 1'b0, 1'b0, 1'b1, "R10");
        chk("R10", "loss held", los, 1'b1);

        // R7: masked interrupt on both changes
        for (int i = 0; i < WIN; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R7");
        chk("R7", "cleared while masked", los, 1'b0);
        for (int k = 0; k < LIM; k++) step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        chk("R7", "set while masked", los, 1'b1);

        // R1: manual reset from the clear state
        for (int i = 0; i < WIN; i++) step(1'b1, 1'b1, 1'b0, 1'b1, "R5");
        chk("R1", "clear before manual reset", los, 1'b0);
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule